// File: doc/BRIEF.md
# Status-Flag ALU with Memory-Target Mode

This block pairs an 8-bit arithmetic/logic unit with an 8-bit processor status word. Each accepted command carries an operation code, the accumulator byte, the byte at the location addressed by the X index register, and the operand byte the addressing mode fetched. Arithmetic and logic commands return a result byte plus a destination select. Commands that only touch flags return a beat that writes nothing. The status word changes on the same clock edge that accepts the command, so the next command sees the new flags.

A mode flag in the status word picks the target of arithmetic and logic. When the flag is clear, the left operand and the destination are the accumulator. When it is set, both are the memory byte addressed through X. The same command set includes single-flag set and clear commands and a bit-test command. The overflow flag is sticky: arithmetic can set it but never clear it.

Commands enter on a valid/ready input channel and leave on a valid/ready output channel. The output beat is held in one register. The input is ready whenever that register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low with a beat pending, the block accepts nothing, the status word does not change, and the pending beat stays stable.

Top module: `sfa_top`

## Requirements
- R1: After synchronous reset, `psr_o` reads 0x04, with only interrupt-disable set. `out_valid` is 0 and `in_ready` is 1.
- R2: The status bit positions are carry 0, zero 1, interrupt-disable 2, decimal 3, break 4, mode 5, overflow 6 and negative 7. The command codes are SEC=7 and CLC=8 for carry, SEI=9 and CLI=10 for interrupt-disable, SED=11 and CLD=12 for decimal, and SETM=13 and CLM=14 for mode. Each of these sets or clears only its own bit.
- R3: CLV (code 15) clears overflow. Overflow is set only by ADC or SBC on signed overflow, or by BIT. Arithmetic never clears it. No command sets it without one of these causes.
- R4: ADC (code 0) returns lhs + operand + carry. The carry-out goes to the carry flag. Overflow is set when the signed sum leaves the range -128..+127. Adding operands of opposite sign never sets overflow.
- R5: SBC (code 1) returns lhs - operand - (1 - carry). Carry becomes 1 when no borrow occurred. Overflow is set when the signed difference leaves the range -128..+127.
- R6: For ADC, SBC, AND (2), ORA (3) and EOR (4), the mode bit selects the left operand and the destination. When the mode bit is 0, the left operand is the accumulator and `res_dest`=0. When it is 1, the left operand is the X-addressed byte and `res_dest`=1. LDA (5) returns the operand byte with `res_dest`=0 in either mode.
- R7: For codes 0 to 5, negative takes bit 7 of the result and zero is set exactly when the result is 0x00. AND, ORA, EOR and LDA leave carry unchanged.
- R8: BIT (code 6) copies operand bit 6 into overflow and operand bit 7 into negative. It sets zero when accumulator AND operand is 0x00, and it leaves carry unchanged.
- R9: The break bit stays 0 after reset whatever is applied.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0. The pending beat's `res_data`, `res_dest` and `res_wr` hold stable, and `psr_o` does not change.
- R11: Every accepted command yields one output beat. `res_wr` is 1 for codes 0 to 5 and 0 for BIT and the flag commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Command accepted this cycle when valid |
| op_code | input | 4 | Command code |
| acc_in | input | 8 | Accumulator byte |
| memx_in | input | 8 | Byte addressed through X |
| opnd_in | input | 8 | Operand byte from the addressing mode |
| out_valid | output | 1 | Result beat pending |
| out_ready | input | 1 | Consumer takes the beat |
| res_data | output | 8 | Result byte |
| res_dest | output | 1 | 0 = accumulator, 1 = X-addressed byte |
| res_wr | output | 1 | Result must be written |
| psr_o | output | 8 | Processor status word |

## Verification
A command accepted on one rising edge changes `psr_o` and loads the output beat on that same edge. Both are due one cycle after the command is driven. The bench drives on a falling edge, lets one rising edge accept the command, and samples on the next falling edge. For back-pressure, the bench holds `out_ready` low across several cycles. It checks the held beat and the unchanged status in each of those cycles, then checks that the stalled command lands one cycle after release.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
  typedef enum logic [3:0] {
    OP_ADC  = 4'd0,  OP_SBC = 4'd1,  OP_AND = 4'd2,  OP_ORA = 4'd3,
    OP_EOR  = 4'd4,  OP_LDA = 4'd5,  OP_BIT = 4'd6,  OP_SEC = 4'd7,
    OP_CLC  = 4'd8,  OP_SEI = 4'd9,  OP_CLI = 4'd10, OP_SED = 4'd11,
    OP_CLD  = 4'd12, OP_SETM = 4'd13, OP_CLM = 4'd14, OP_CLV = 4'd15
  } op_e;

  localparam int PSR_W = 8;
  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_I = 2;
  localparam int F_D = 3;
  localparam int F_B = 4;
  localparam int F_M = 5;
  localparam int F_V = 6;
  localparam int F_N = 7;
  localparam logic [PSR_W-1:0] PSR_RESET = 8'h04;
endpackage

// File: rtl/sfa_alu.sv
module sfa_alu
  import sfa_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] mem_x,
  input  logic [DW-1:0] opnd,
  input  logic          m_mode,
  input  logic          c_in,
  input  logic          v_in,
  output logic [DW-1:0] res,
  output logic          to_mem,
  output logic          wr,
  output logic          c_new,
  output logic          v_new,
  output logic          n_new,
  output logic          z_new,
  output logic          upd_c,
  output logic          upd_v,
  output logic          upd_nz
);
  localparam int MSB = DW - 1;
  localparam int SGN = DW - 2;

  logic          is_alu;
  logic [DW-1:0] lhs;
  logic [DW:0]   sum_add;
  logic [DW:0]   sum_sub;
  logic          ovf_add;
  logic          ovf_sub;

  always_comb begin
    is_alu  = (op == OP_ADC) || (op == OP_SBC) || (op == OP_AND) ||
              (op == OP_ORA) || (op == OP_EOR);
    lhs     = (m_mode && is_alu) ? mem_x : acc;
    sum_add = {1'b0, lhs} + {1'b0, opnd} + {{DW{1'b0}}, c_in};
    sum_sub = {1'b0, lhs} + {1'b0, ~opnd} + {{DW{1'b0}}, c_in};
    ovf_add = (lhs[MSB] == opnd[MSB]) && (sum_add[MSB] != lhs[MSB]);
    ovf_sub = (lhs[MSB] != opnd[MSB]) && (sum_sub[MSB] != lhs[MSB]);

    res    = '0;
    wr     = 1'b0;
    to_mem = m_mode && is_alu;
    c_new  = c_in;
    v_new  = v_in;
    upd_c  = 1'b0;
    upd_v  = 1'b0;
    upd_nz = 1'b0;
    unique case (op)
      OP_ADC: begin
        res = sum_add[DW-1:0]; c_new = sum_add[DW]; v_new = v_in | ovf_add;
        upd_c = 1'b1; upd_v = 1'b1; upd_nz = 1'b1; wr = 1'b1;
      end
      OP_SBC: begin
        res = sum_sub[DW-1:0]; c_new = sum_sub[DW]; v_new = v_in | ovf_sub;
        upd_c = 1'b1; upd_v = 1'b1; upd_nz = 1'b1; wr = 1'b1;
      end
      OP_AND: begin res = lhs & opnd; upd_nz = 1'b1; wr = 1'b1; end
      OP_ORA: begin res = lhs | opnd; upd_nz = 1'b1; wr = 1'b1; end
      OP_EOR: begin res = lhs ^ opnd; upd_nz = 1'b1; wr = 1'b1; end
      OP_LDA: begin res = opnd; upd_nz = 1'b1; wr = 1'b1; end
      OP_BIT: begin
        res = acc & opnd; v_new = opnd[SGN]; upd_v = 1'b1; upd_nz = 1'b1;
      end
      default: ;
    endcase

    if (op == OP_BIT) n_new = opnd[MSB];
    else              n_new = res[MSB];
    z_new = (res == '0);
  end
endmodule

// File: rtl/sfa_flag_cmd.sv
module sfa_flag_cmd
  import sfa_pkg::*;
(
  input  op_e              op,
  output logic [PSR_W-1:0] set_m,
  output logic [PSR_W-1:0] clr_m
);
  always_comb begin
    set_m = '0;
    clr_m = '0;
    unique case (op)
      OP_SEC:  set_m[F_C] = 1'b1;
      OP_CLC:  clr_m[F_C] = 1'b1;
      OP_SEI:  set_m[F_I] = 1'b1;
      OP_CLI:  clr_m[F_I] = 1'b1;
      OP_SED:  set_m[F_D] = 1'b1;
      OP_CLD:  clr_m[F_D] = 1'b1;
      OP_SETM: set_m[F_M] = 1'b1;
      OP_CLM:  clr_m[F_M] = 1'b1;
      OP_CLV:  clr_m[F_V] = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sfa_psr.sv
module sfa_psr
  import sfa_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  op_e              op,
  input  logic             c_new,
  input  logic             v_new,
  input  logic             n_new,
  input  logic             z_new,
  input  logic             upd_c,
  input  logic             upd_v,
  input  logic             upd_nz,
  input  logic [PSR_W-1:0] set_m,
  input  logic [PSR_W-1:0] clr_m,
  output logic [PSR_W-1:0] psr_q
);
  logic [PSR_W-1:0] alu_nxt;
  logic [PSR_W-1:0] psr_d;

  always_comb begin
    alu_nxt = psr_q;
    if (upd_c)  alu_nxt[F_C] = c_new;
    if (upd_v)  alu_nxt[F_V] = v_new;
    if (upd_nz) begin
      alu_nxt[F_N] = n_new;
      alu_nxt[F_Z] = z_new;
    end
  end

  for (genvar b = 0; b < PSR_W; b++) begin : g_bit
    assign psr_d[b] = set_m[b] | (~clr_m[b] & alu_nxt[b]);
  end

  always_ff @(posedge clk) begin
    if (rst)       psr_q <= PSR_RESET;
    else if (fire) psr_q <= psr_d;
  end

  // R3
  v_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(psr_q[F_V]) |-> $past(fire && (op == OP_ADC || op == OP_SBC || op == OP_BIT)));
  // R3
  v_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fire && op == OP_CLV |=> !psr_q[F_V]);
  // R9
  brk_zero_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !psr_q[F_B]);
  // R2
  irq_only_chk: assert property (@(posedge clk) disable iff (rst)
    fire && !(op == OP_SEI || op == OP_CLI) |=> $stable(psr_q[F_I]));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(psr_q));
endmodule

// File: rtl/sfa_top.sv
module sfa_top
  import sfa_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    op_code,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] memx_in,
  input  logic [DW-1:0] opnd_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] res_data,
  output logic          res_dest,
  output logic          res_wr,
  output logic [7:0]    psr_o
);
  op_e              op;
  logic             fire;
  logic [DW-1:0]    alu_res;
  logic             alu_to_mem, alu_wr;
  logic             c_new, v_new, n_new, z_new;
  logic             upd_c, upd_v, upd_nz;
  logic [PSR_W-1:0] set_m, clr_m;
  logic [PSR_W-1:0] psr_q;

  assign op       = op_e'(op_code);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign psr_o    = psr_q;

  sfa_alu #(.DW(DW)) u_alu (
    .op(op), .acc(acc_in), .mem_x(memx_in), .opnd(opnd_in),
    .m_mode(psr_q[F_M]), .c_in(psr_q[F_C]), .v_in(psr_q[F_V]),
    .res(alu_res), .to_mem(alu_to_mem), .wr(alu_wr),
    .c_new(c_new), .v_new(v_new), .n_new(n_new), .z_new(z_new),
    .upd_c(upd_c), .upd_v(upd_v), .upd_nz(upd_nz)
  );

  sfa_flag_cmd u_cmd (.op(op), .set_m(set_m), .clr_m(clr_m));

  sfa_psr u_psr (
    .clk(clk), .rst(rst), .fire(fire), .op(op),
    .c_new(c_new), .v_new(v_new), .n_new(n_new), .z_new(z_new),
    .upd_c(upd_c), .upd_v(upd_v), .upd_nz(upd_nz),
    .set_m(set_m), .clr_m(clr_m), .psr_q(psr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_data  <= '0;
      res_dest  <= 1'b0;
      res_wr    <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      res_data  <= alu_res;
      res_dest  <= alu_to_mem;
      res_wr    <= alu_wr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(res_data) &&
                                $stable(res_dest) && $stable(res_wr));
  // R6
  dest_mode_chk: assert property (@(posedge clk) disable iff (rst)
    fire && (op == OP_ADC || op == OP_SBC || op == OP_AND || op == OP_ORA || op == OP_EOR)
      |=> res_dest == $past(psr_q[F_M]));
  // R11
  beat_out_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);
endmodule

// File: tb/sim_sfa_top.sv
module sim_sfa_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] op_code = 4'd0;
  logic [7:0] acc_in = 8'd0, memx_in = 8'd0, opnd_in = 8'd0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] res_data;
  logic       res_dest, res_wr;
  logic [7:0] psr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sfa_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_code(op_code), .acc_in(acc_in), .memx_in(memx_in), .opnd_in(opnd_in),
    .out_valid(out_valid), .out_ready(out_ready), .res_data(res_data),
    .res_dest(res_dest), .res_wr(res_wr), .psr_o(psr_o)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input int op, input int a, input int mx, input int m);
    @(negedge clk);
    op_code = op[3:0]; acc_in = a[7:0]; memx_in = mx[7:0]; opnd_in = m[7:0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(psr_o, 8'h04, "R1 psr");
    chk(out_valid, 0, "R1 out_valid");
    chk(in_ready, 1, "R1 in_ready");
  endtask

  task automatic t_flags;
    apply(7, 0, 0, 0);  chk(psr_o, 8'h05, "R2 SEC");
    chk(res_wr, 0, "R11 flag cmd no write");
    chk(out_valid, 1, "R11 beat");
    apply(11, 0, 0, 0); chk(psr_o, 8'h0D, "R2 SED");
    apply(13, 0, 0, 0); chk(psr_o, 8'h2D, "R2 SETM");
    apply(8, 0, 0, 0);  chk(psr_o, 8'h2C, "R2 CLC");
    apply(12, 0, 0, 0); chk(psr_o, 8'h24, "R2 CLD");
    apply(10, 0, 0, 0); chk(psr_o, 8'h20, "R2 CLI");
    apply(9, 0, 0, 0);  chk(psr_o, 8'h24, "R2 SEI");
    apply(14, 0, 0, 0); chk(psr_o, 8'h04, "R2 CLM");
  endtask

  task automatic t_adc;
    apply(0, 8'h50, 8'h00, 8'h50);
    chk(res_data, 8'hA0, "R4 adc sum");
    chk(psr_o, 8'hC4, "R4 adc overflow N V");
    chk(res_wr, 1, "R11 adc writes");
    apply(0, 8'hFF, 0, 8'h01);
    chk(res_data, 8'h00, "R4 adc wrap");
    chk(psr_o, 8'h47, "R3 V sticky, R7 Z, R4 carry");
    apply(15, 0, 0, 0); chk(psr_o, 8'h07, "R3 CLV");
    apply(0, 8'h7F, 0, 8'h80);
    chk(res_data, 8'h00, "R4 adc carry-in");
    chk(psr_o, 8'h07, "R4 opposite signs no V");
  endtask

  task automatic t_sbc;
    apply(7, 0, 0, 0);
    apply(1, 8'h50, 0, 8'hB0);
    chk(res_data, 8'hA0, "R5 sbc value");
    chk(psr_o, 8'hC4, "R5 sbc overflow borrow");
    apply(15, 0, 0, 0); apply(7, 0, 0, 0);
    apply(1, 8'h05, 0, 8'h03);
    chk(res_data, 8'h02, "R5 sbc no borrow");
    chk(psr_o, 8'h05, "R5 carry kept");
    apply(1, 8'h03, 0, 8'h05);
    chk(res_data, 8'hFE, "R5 sbc negative");
    chk(psr_o, 8'h84, "R5 borrow N");
    apply(1, 8'h10, 0, 8'h01);
    chk(res_data, 8'h0E, "R5 sbc with borrow in");
  endtask

  task automatic t_mode;
    apply(8, 0, 0, 0); apply(13, 0, 0, 0);
    apply(0, 8'h10, 8'h20, 8'h01);
    chk(res_data, 8'h21, "R6 mem lhs");
    chk(res_dest, 1, "R6 dest mem");
    apply(2, 8'hFF, 8'h0F, 8'h3C);
    chk(res_data, 8'h0C, "R6 and mem lhs");
    chk(res_dest, 1, "R6 and dest");
    apply(5, 8'h11, 8'h22, 8'h9A);
    chk(res_data, 8'h9A, "R6 lda");
    chk(res_dest, 0, "R6 lda dest acc");
    chk(psr_o, 8'hA4, "R7 lda N");
    apply(14, 0, 0, 0);
    apply(0, 8'h10, 8'h20, 8'h01);
    chk(res_data, 8'h11, "R6 acc lhs");
    chk(res_dest, 0, "R6 dest acc");
  endtask

  task automatic t_logic;
    apply(7, 0, 0, 0);
    apply(4, 8'hAA, 8'h00, 8'hAA);
    chk(res_data, 8'h00, "R7 eor zero");
    chk(psr_o, 8'h07, "R7 Z set C kept");
    apply(3, 8'h80, 8'h00, 8'h01);
    chk(res_data, 8'h81, "R7 ora");
    chk(psr_o, 8'h85, "R7 N set");
  endtask

  task automatic t_bit;
    apply(0 + 6, 8'h0F, 8'h00, 8'hC0);
    chk(psr_o, 8'hC7, "R8 bit N V Z");
    chk(res_wr, 0, "R11 bit no write");
    apply(6, 8'h01, 8'h00, 8'h01);
    chk(psr_o, 8'h05, "R8 bit clears V N Z, C kept");
  endtask

  task automatic t_backpressure;
    apply(8, 0, 0, 0);
    chk(psr_o, 8'h04, "R10 setup");
    out_ready = 1'b0;
    @(negedge clk);
    op_code = 4'd7; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(in_ready, 0, "R10 in_ready low");
      chk(out_valid, 1, "R10 beat held");
      chk(res_wr, 0, "R10 beat stable");
      chk(psr_o, 8'h04, "R10 status frozen");
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(psr_o, 8'h05, "R10 stalled cmd lands");
    chk(psr_o[4], 0, "R9 break zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_flags;
    t_adc;
    t_sbc;
    t_mode;
    t_logic;
    t_bit;
    t_backpressure;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule